// File: doc/BRIEF.md
# Serial Transceiver with Receiver Mute and Break Insertion

This block is an asynchronous serial transceiver with 8-bit data, one start bit and one stop bit. A small byte-wide register bus controls it. One bus address is used for data in both directions: a write fills a transmit holding register and a read drains a receive holding register. Two separate 16x oversampling tick generators, one for each direction, set the line rates. A single baud register programs both of them.

The receiver can be muted so that other stations' traffic on a shared line is ignored. Software sets the mute bit. Hardware clears it on a wake-up event, and a control bit picks which event counts. The first kind is a full frame time of idle line. The second kind is a received character with its top data bit set, and that character is delivered. The transmitter can also insert one break word. Software raises the break request and then drops it. The break goes out when the word currently on the line has finished, and it goes ahead of any byte waiting in the holding register.

Top module: `uart_mute_xcvr`

## Requirements
- R1: After reset, the status register (address 0) reads 06h, the control register (address 2) reads 00h, the baud register (address 3) reads 00h, and `txd` is high. Status bits: bit 0 is receive data ready, bit 1 is transmit holding empty, bit 2 is transmitter fully idle. Control bits: bit 0 is break request, bit 1 is mute, bit 2 selects address-mark wake-up (1) or idle-line wake-up (0).
- R2: A write to address 1 loads the transmit holding register. The byte is then sent as a low start bit, 8 data bits LSB first and a high stop bit. Each bit lasts 16 transmit ticks, and the line stays high between frames.
- R3: In the baud register, bits 7:6 are the prescaler P, bits 5:3 the transmit divider T and bits 2:0 the receive divider R. The transmit tick period is BASE_DIV*(P+1)*2^T clocks. The receive tick period is BASE_DIV*(P+1)*2^R clocks.
- R4: The receiver oversamples by 16 and decides each bit by a majority of three samples around mid-bit, so a single short glitch is rejected. A valid frame received while not muted loads the receive holding register and sets ready. A read of address 1 returns the byte and clears ready.
- R5: A frame whose stop bit is sampled low is dropped. Ready stays clear and the receive holding register keeps its old value.
- R6: Software sets and clears the mute bit through the control register. While muted, received frames neither set ready nor change the receive holding register, except for the wake-up character of R7.
- R7: With address-mark wake-up selected, a character whose bit 7 is 1 clears mute while muted. That character is stored and sets ready. Characters with bit 7 clear are ignored and leave mute set, and idle periods do not wake.
- R8: With idle-line wake-up selected, 160 receive ticks of continuous high line with the receiver idle clears mute. This only happens once at least one byte has been delivered since reset; before that, mute stays set.
- R9: With address-mark wake-up selected and ready set, control writes leave the mute bit unchanged while the other control bits are still written. Once ready is cleared, the mute bit is writable again.
- R10: When the break request goes from 1 to 0, the transmitter sends one break word after the current frame. The break word is 10 bit times low followed by one high bit time, and it is sent before any byte already waiting in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 status, 1 data, 2 control, 3 baud |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read clears ready) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| rx_ready | output | 1 | Receive holding register has an unread byte |
| tx_empty | output | 1 | Transmit holding register can take a byte |

## Verification
The bench sets BASE_DIV to 1. With a zero baud register a tick then arrives every clock and a bit lasts 16 cycles, so the wake-up windows of 160 ticks take only a few hundred cycles. Changing the baud register to a transmit divider of 1 or a prescaler of 1 doubles a bit to 32 cycles, and the bench uses this to check that each field drives its own direction. The short bit time also lets a one-cycle glitch land inside the three-sample voting window.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

  localparam int OSR        = 16;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 10;
  localparam int PER_W      = 20;

  typedef enum logic [1:0] {
    ADR_STAT = 2'd0,
    ADR_DATA = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_BAUD = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BRK, TX_BRK_STOP
  } tx_st_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_st_e;

  // Clocks per oversampling tick
  function automatic logic [PER_W-1:0] tick_period(input logic [PER_W-1:0] base,
                                                   input logic [1:0] pre,
                                                   input logic [2:0] div);
    logic [PER_W-1:0] p;
    p = base * (PER_W'(pre) + PER_W'(1));
    return p << div;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt <= period || $past(period) != period)); // R3
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_mute_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              brk_req,
  output logic              load,
  output logic              txd,
  output logic              busy,
  output logic              brk_pend
);
  localparam int TCW = $clog2(OSR);
  localparam int BCW = $clog2(FRAME_BITS + 1);
  localparam logic [TCW-1:0] LAST_TICK = TCW'(OSR - 1);
  localparam logic [BCW-1:0] BRK_LAST  = BCW'(FRAME_BITS - 1);

  tx_st_e            st;
  logic [TCW-1:0]    tcnt;
  logic [2:0]        bidx;
  logic [DATA_W-1:0] shreg;
  logic [BCW-1:0]    brk_bits;
  logic              brk_q;
  logic              brk_fall;
  logic              bit_end;

  assign brk_fall = brk_q & ~brk_req;
  assign bit_end  = tick && (tcnt == LAST_TICK);
  assign load     = (st == TX_IDLE) && !brk_pend && hold_valid;
  assign busy     = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      brk_bits <= '0;
      brk_q    <= 1'b0;
      brk_pend <= 1'b0;
      txd      <= 1'b1;
    end else begin
      brk_q <= brk_req;
      if (st == TX_IDLE) begin
        tcnt <= '0;
        if (brk_pend) begin
          st       <= TX_BRK;
          brk_bits <= '0;
          brk_pend <= 1'b0;
          txd      <= 1'b0;
        end else if (load) begin
          st    <= TX_START;
          shreg <= hold_data;
          txd   <= 1'b0;
        end
      end else if (tick) begin
        tcnt <= bit_end ? '0 : tcnt + TCW'(1);
        if (bit_end) begin
          case (st)
            TX_START: begin
              st   <= TX_DATA;
              bidx <= '0;
              txd  <= shreg[0];
            end
            TX_DATA: begin
              if (bidx == 3'd7) begin
                st  <= TX_STOP;
                txd <= 1'b1;
              end else begin
                bidx  <= bidx + 3'd1;
                txd   <= shreg[1];
                shreg <= {1'b0, shreg[DATA_W-1:1]};
              end
            end
            TX_BRK: begin
              if (brk_bits == BRK_LAST) begin
                st  <= TX_BRK_STOP;
                txd <= 1'b1;
              end else begin
                brk_bits <= brk_bits + BCW'(1);
              end
            end
            default: st <= TX_IDLE;
          endcase
        end
      end
      if (brk_fall) brk_pend <= 1'b1;
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE) |-> txd); // R2
  AST_BRK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fall |=> brk_pend); // R10
  AST_BRK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_BRK) |-> !txd); // R10
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_mute_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_async,
  output logic              frame_done,
  output logic              stop_ok,
  output logic [DATA_W-1:0] rx_byte,
  output logic              idle_evt
);
  localparam int TCW        = $clog2(OSR);
  localparam int IDLE_TICKS = OSR * FRAME_BITS;
  localparam int ICW        = $clog2(IDLE_TICKS + 1);
  localparam logic [TCW-1:0] SMP_A     = TCW'(OSR / 2 - 1);
  localparam logic [TCW-1:0] SMP_B     = TCW'(OSR / 2);
  localparam logic [TCW-1:0] SMP_C     = TCW'(OSR / 2 + 1);
  localparam logic [TCW-1:0] LAST_TICK = TCW'(OSR - 1);
  localparam logic [ICW-1:0] IDLE_LAST = ICW'(IDLE_TICKS - 1);
  localparam logic [ICW-1:0] IDLE_FULL = ICW'(IDLE_TICKS);

  rx_st_e            st;
  logic              rx_m, rx_s;
  logic [TCW-1:0]    rcnt;
  logic [1:0]        smp;
  logic [2:0]        bidx;
  logic [DATA_W-1:0] shreg;
  logic [ICW-1:0]    icnt;
  logic              vote;
  logic              at_mid;

  assign vote   = maj3(smp[0], smp[1], rx_s);
  assign at_mid = tick && (rcnt == SMP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd_async;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      rcnt       <= '0;
      smp        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
      stop_ok    <= 1'b0;
      rx_byte    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (st == RX_IDLE) begin
        if (tick && !rx_s) begin
          st   <= RX_START;
          rcnt <= '0;
        end
      end else if (tick) begin
        rcnt <= (rcnt == LAST_TICK) ? '0 : rcnt + TCW'(1);
        if (rcnt == SMP_A) smp[0] <= rx_s;
        if (rcnt == SMP_B) smp[1] <= rx_s;
        if (at_mid) begin
          case (st)
            RX_START: if (vote) st <= RX_IDLE;
            RX_DATA:  shreg <= {vote, shreg[DATA_W-1:1]};
            RX_STOP: begin
              frame_done <= 1'b1;
              stop_ok    <= vote;
              rx_byte    <= shreg;
              st         <= RX_IDLE;
            end
            default: ;
          endcase
        end
        if (rcnt == LAST_TICK) begin
          if (st == RX_START) begin
            st   <= RX_DATA;
            bidx <= '0;
          end else if (st == RX_DATA) begin
            if (bidx == 3'd7) st <= RX_STOP;
            else              bidx <= bidx + 3'd1;
          end
        end
      end
    end
  end

  // Idle-line detector: counts ticks of high line while the receiver rests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt     <= '0;
      idle_evt <= 1'b0;
    end else begin
      idle_evt <= 1'b0;
      if (st != RX_IDLE || !rx_s) begin
        icnt <= '0;
      end else if (tick && icnt != IDLE_FULL) begin
        icnt <= icnt + ICW'(1);
        if (icnt == IDLE_LAST) idle_evt <= 1'b1;
      end
    end
  end

  AST_DONE_LEAVES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (st == RX_IDLE)); // R4
  AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> $past(rx_s)); // R8
endmodule

// File: rtl/uart_mute_xcvr.sv
module uart_mute_xcvr
  import uart_mute_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_ready,
  output logic       tx_empty
);
  localparam logic [PER_W-1:0] BASE_W = PER_W'(BASE_DIV);
  localparam int N_RATE = 2;  // index 0: transmit, 1: receive

  logic [7:0]        baud_q;
  logic [PER_W-1:0]  per_v [N_RATE];
  logic [N_RATE-1:0] tick_v;

  logic [DATA_W-1:0] tdr, rx_hold;
  logic              tdr_full, rx_ready_q, rx_seen;
  logic              brk_q, mute_q, wake_q;

  logic              tx_load, tx_busy, brk_pend;
  logic              frame_done, stop_ok, idle_evt;
  logic [DATA_W-1:0] rx_byte;

  logic wr_data, wr_ctrl, wr_baud, rd_data;
  logic frame_good, deliver, addr_wake, idle_wake, wake_clr, mute_locked;

  assign per_v[0] = tick_period(BASE_W, baud_q[7:6], baud_q[5:3]);
  assign per_v[1] = tick_period(BASE_W, baud_q[7:6], baud_q[2:0]);

  for (genvar g = 0; g < N_RATE; g++) begin : g_rate
    uart_baud_gen #(.CNT_W(PER_W)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (per_v[g]),
      .tick   (tick_v[g])
    );
  end

  uart_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_v[0]),
    .hold_valid (tdr_full),
    .hold_data  (tdr),
    .brk_req    (brk_q),
    .load       (tx_load),
    .txd        (txd),
    .busy       (tx_busy),
    .brk_pend   (brk_pend)
  );

  uart_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_v[1]),
    .rxd_async  (rxd),
    .frame_done (frame_done),
    .stop_ok    (stop_ok),
    .rx_byte    (rx_byte),
    .idle_evt   (idle_evt)
  );

  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_baud = bus_wr && (bus_addr == ADR_BAUD);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);

  // Wake-up and delivery events
  assign frame_good  = frame_done && stop_ok;
  assign addr_wake   = frame_good && mute_q && wake_q && rx_byte[DATA_W-1];
  assign idle_wake   = idle_evt && mute_q && !wake_q && rx_seen;
  assign wake_clr    = addr_wake || idle_wake;
  assign deliver     = frame_good && (!mute_q || addr_wake);
  assign mute_locked = wake_q && rx_ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q     <= '0;
      tdr        <= '0;
      tdr_full   <= 1'b0;
      rx_hold    <= '0;
      rx_ready_q <= 1'b0;
      rx_seen    <= 1'b0;
      brk_q      <= 1'b0;
      mute_q     <= 1'b0;
      wake_q     <= 1'b0;
    end else begin
      if (wr_baud) baud_q <= bus_wdata;

      if (wr_data) begin
        tdr      <= bus_wdata;
        tdr_full <= 1'b1;
      end else if (tx_load) begin
        tdr_full <= 1'b0;
      end

      if (rd_data) rx_ready_q <= 1'b0;
      if (deliver) begin
        rx_hold    <= rx_byte;
        rx_ready_q <= 1'b1;
        rx_seen    <= 1'b1;
      end

      if (wr_ctrl) begin
        brk_q  <= bus_wdata[0];
        wake_q <= bus_wdata[2];
        if (!mute_locked) mute_q <= bus_wdata[1];
      end
      if (wake_clr) mute_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_STAT: bus_rdata = {5'd0, !tx_busy && !tdr_full && !brk_pend, !tdr_full, rx_ready_q};
      ADR_DATA: bus_rdata = rx_hold;
      ADR_CTRL: bus_rdata = {5'd0, wake_q, mute_q, brk_q};
      default:  bus_rdata = baud_q;
    endcase
  end

  assign rx_ready = rx_ready_q;
  assign tx_empty = !tdr_full;

  AST_BAD_STOP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_ok) |=> $stable(rx_hold)); // R5
  AST_MUTE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mute_q && !addr_wake) |=> $stable(rx_hold)); // R6
  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wake |=> (!mute_q && rx_ready_q)); // R7
  AST_IDLE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !rx_seen && !wr_ctrl && !addr_wake) |=> (mute_q == $past(mute_q))); // R8
  AST_MUTE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && mute_locked && !wake_clr) |=> $stable(mute_q)); // R9
endmodule

// File: tb/tb_uart_mute_xcvr.sv
module tb_uart_mute_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       rx_ready;
  logic       tx_empty;

  int checks = 0;
  int errors = 0;
  int bitc = 16;          // transmit bit length in clocks seen by the monitor
  logic [8:0] exp_q[$];   // bit 8 set marks a break word
  logic [7:0] rv;

  always #5 clk = ~clk;

  uart_mute_xcvr #(.BASE_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .rx_ready(rx_ready), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    bus_read(a, v);
    check(v == e, req, {1'b0, v}, {1'b0, e});
  endtask

  // Drive one frame on rxd; glitch_bit >= 0 flips one data bit for a single clock near mid-bit
  task automatic send_rx(input logic [7:0] b, input logic stop, input int bt, input int glitch_bit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      if (i == glitch_bit) begin
        repeat (bt / 2) @(negedge clk);
        rxd = ~b[i];
        @(negedge clk);
        rxd = b[i];
        repeat (bt - bt / 2 - 1) @(negedge clk);
      end else begin
        repeat (bt) @(negedge clk);
      end
    end
    rxd = stop;
    repeat (bt) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic drain_tx();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4 * bitc) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: decode frames on txd and compare against the scoreboard queue
  initial begin
    forever begin
      logic [7:0] d;
      logic       st0, sp;
      logic [8:0] got, want;
      @(negedge txd);
      repeat (bitc / 2) @(negedge clk);
      st0 = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (bitc) @(negedge clk);
        d[i] = txd;
      end
      repeat (bitc) @(negedge clk);
      sp = txd;
      got = (!sp && d == 8'h00) ? 9'h100 : {1'b0, d};
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected frame", got, 9'h000);
      end else begin
        want = exp_q.pop_front();
        // R2 data frames, R10 break word
        check(!st0 && got == want, want[8] ? "R10 break" : "R2 frame", got, want);
      end
      wait (txd == 1'b1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", {8'd0, txd}, 9'd1);
    expect_reg(2'd0, 8'h06, "R1 status");
    expect_reg(2'd2, 8'h00, "R1 control");
    expect_reg(2'd3, 8'h00, "R1 R3 baud");

    // R8: mute before any delivered byte; idle-line must not wake
    bus_write(2'd2, 8'h02);
    send_rx(8'h00, 1'b0, 16, -1);          // bad-stop frame, not delivered
    repeat (14 * 16) @(negedge clk);
    expect_reg(2'd2, 8'h02, "R8 no wake before first byte");
    bus_write(2'd2, 8'h00);
    expect_reg(2'd2, 8'h00, "R6 software clear of mute");

    // R2/R10: byte, break pulse, queued byte
    exp_q.push_back(9'h05A);
    exp_q.push_back(9'h100);
    exp_q.push_back(9'h03C);
    bus_write(2'd1, 8'h5A);
    bus_write(2'd2, 8'h01);
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h3C);
    drain_tx();
    expect_reg(2'd0, 8'h06, "R2 transmitter idle again");

    // R3: transmit divider 1 doubles the bit
    bus_write(2'd3, 8'h08);
    bitc = 32;
    exp_q.push_back(9'h0C3);
    bus_write(2'd1, 8'hC3);
    drain_tx();
    bus_write(2'd3, 8'h00);
    bitc = 16;

    // R3: prescaler 1 doubles the receive bit
    bus_write(2'd3, 8'h40);
    send_rx(8'h6E, 1'b1, 32, -1);
    expect_reg(2'd1, 8'h6E, "R3 prescaled receive");
    bus_write(2'd3, 8'h00);

    // R4: reception with a glitch inside the voting window
    send_rx(8'h96, 1'b1, 16, 2);
    expect_reg(2'd0, 8'h07, "R4 ready set");
    expect_reg(2'd1, 8'h96, "R4 majority data");
    expect_reg(2'd0, 8'h06, "R4 ready cleared by read");

    // R5: bad stop bit drops the frame
    send_rx(8'h44, 1'b0, 16, -1);
    expect_reg(2'd0, 8'h06, "R5 no ready on bad stop");
    expect_reg(2'd1, 8'h96, "R5 holding kept");
    repeat (3 * 16) @(negedge clk);

    // R6 and R8: mute blocks data, idle line wakes
    bus_write(2'd2, 8'h02);
    expect_reg(2'd2, 8'h02, "R6 mute set");
    send_rx(8'h11, 1'b1, 16, -1);
    expect_reg(2'd0, 8'h06, "R6 muted frame no ready");
    expect_reg(2'd1, 8'h96, "R6 muted frame holding kept");
    repeat (12 * 16) @(negedge clk);
    expect_reg(2'd2, 8'h00, "R8 idle wake clears mute");
    send_rx(8'h22, 1'b1, 16, -1);
    expect_reg(2'd1, 8'h22, "R8 delivered after wake");

    // R7 and R9: address-mark wake-up and write lock
    bus_write(2'd2, 8'h06);
    expect_reg(2'd2, 8'h06, "R7 muted in address mode");
    send_rx(8'h35, 1'b1, 16, -1);
    repeat (12 * 16) @(negedge clk);
    expect_reg(2'd0, 8'h06, "R7 plain char ignored");
    expect_reg(2'd2, 8'h06, "R7 idle does not wake");
    send_rx(8'hA5, 1'b1, 16, -1);
    expect_reg(2'd0, 8'h07, "R7 marked char sets ready");
    expect_reg(2'd2, 8'h04, "R7 mute cleared");
    bus_write(2'd2, 8'h07);
    expect_reg(2'd2, 8'h05, "R9 mute write ignored");
    bus_write(2'd2, 8'h04);
    expect_reg(2'd1, 8'hA5, "R7 marked char stored");
    bus_write(2'd2, 8'h06);
    expect_reg(2'd2, 8'h06, "R9 mute writable after read");
    bus_write(2'd2, 8'h00);
    expect_reg(2'd2, 8'h00, "R6 clear in address mode");

    drain_tx();
    finish_run();
  end
endmodule